// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block drives the byte-level side of an in-frame response on a J1850-style serial link. Software holds three request bits, one for each response kind: a single byte, a train of node identifiers under arbitration, or a run of data bytes from one responder. It then pulses a trigger. The sequencer records the request, waits for the end of the main frame and hands bytes one at a time to a bit-level transmitter. That transmitter reports when each byte has ended on the bus and whether this node lost arbitration during it.

When more than one request bit is set, a fixed priority picks the kind. A node-identifier response keeps offering the same identifier after each lost round until it wins. A data response pulls bytes from a source stream and can close with a CRC-8 byte. Every request, including one with no kind bit set, ends with a one-cycle completion pulse, which software uses to clear its trigger.

Top module: `ifr_tx_seq`

## Requirements
- R1: When `trig` is sampled in idle, the kind is picked by priority `sel_single` over `sel_nodes` over `sel_data`, and lower-priority bits are ignored.
- R2: A `trig` with no kind bit set sends nothing, and `done` is high in the cycle after the trigger.
- R3: After an accepted trigger, `tx_valid` stays low until `frame_eod` pulses. For a single-byte or node-ID response, `tx_valid` rises in the cycle after that pulse.
- R4: A single-byte response sends `node_id` exactly once and finishes at the next `byte_end`, with or without a lost-arbitration pulse.
- R5: In a node-ID response, an `arb_lost` pulse seen between the byte handshake and `byte_end` makes the block offer the same `node_id` byte again after that `byte_end`. A `byte_end` with no loss ends the response with `done` in the next cycle.
- R6: A data response takes bytes from the source stream (`src_ready` and `src_valid` both high) and sends them in order. `src_last` marks the final data byte.
- R7: With `crc_en` high at the trigger, a data response sends one extra byte after the last data byte. That byte is the bitwise inverse of a CRC-8 over the data bytes, computed MSB first with polynomial 0x1D (x^8+x^4+x^3+x^2+1) and initial value 0xFF. With `crc_en` low, no extra byte is sent.
- R8: A lost arbitration during a data or CRC byte ends the data response at that byte's `byte_end`. No further byte is requested or sent.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` holds its value.
- R10: `done` is a one-cycle pulse that marks the end of every request. Outputs are idle out of reset, and a new trigger is accepted afterwards.
- R11: A `trig` pulse while a request is pending or in progress is ignored, and the kind latched earlier is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | One-cycle request pulse (software trigger) |
| sel_single | input | 1 | Request a single-byte response |
| sel_nodes | input | 1 | Request a node-ID response with arbitration |
| sel_data | input | 1 | Request a multi-byte single-responder response |
| crc_en | input | 1 | Append a CRC byte to a data response |
| node_id | input | 8 | This node's identifier byte |
| frame_eod | input | 1 | Pulse: main frame has ended |
| src_valid | input | 1 | Data source has a byte |
| src_byte | input | 8 | Data byte from source |
| src_last | input | 1 | Current source byte is the final one |
| src_ready | output | 1 | Sequencer takes a source byte |
| tx_valid | output | 1 | Byte offered to the bit-level transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| arb_lost | input | 1 | Pulse: this node lost arbitration on the current byte |
| byte_end | input | 1 | Pulse: the current bus byte has finished |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a node-ID response that loses arbitration several times in a row. Each loss must be followed by the same identifier and must not end the response early. The bench plays the transmitter itself: it accepts each offered byte after a deliberate stall, injects a lost-arbitration pulse before the byte end for a chosen number of rounds, and only then lets the byte win. The bench sweeps all eight request-bit combinations with CRC on and off. It also raises a second trigger while a request is armed, and it checks the CRC byte against the known check value of the nine ASCII digits.

// File: rtl/ifr_tx_pkg.sv
package ifr_tx_pkg;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_SINGLE,
        KIND_NODES,
        KIND_DATA
    } ifr_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/ifr_kind_pick.sv
module ifr_kind_pick
    import ifr_tx_pkg::*;
#(
    parameter int N_KIND = 3
) (
    input  logic [N_KIND-1:0] req,
    output ifr_kind_e         kind
);
    // req[0] has top priority, req[N_KIND-1] the lowest
    always_comb begin
        kind = KIND_NONE;
        for (int i = N_KIND - 1; i >= 0; i--) begin
            if (req[i]) begin
                kind = ifr_kind_e'(i + 1);
            end
        end
    end
endmodule

// File: rtl/ifr_crc_step.sv
module ifr_crc_step #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h1D
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data,
    output logic [W-1:0] crc_out
);
    always_comb begin
        logic [W-1:0] c;
        logic         fb;
        c = crc_in;
        for (int i = W - 1; i >= 0; i--) begin
            fb = c[W-1] ^ data[i];
            c  = {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq
    import ifr_tx_pkg::*;
#(
    parameter int               BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] CRC_POLY = 8'h1D,
    parameter logic [BYTE_W-1:0] CRC_INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              sel_single,
    input  logic              sel_nodes,
    input  logic              sel_data,
    input  logic              crc_en,
    input  logic [BYTE_W-1:0] node_id,
    input  logic              frame_eod,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_byte,
    input  logic              src_last,
    output logic              src_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_ready,
    input  logic              arb_lost,
    input  logic              byte_end,
    output logic              done
);

    typedef struct packed {
        seq_state_e        st;
        ifr_kind_e         kind;
        logic [BYTE_W-1:0] id;
        logic [BYTE_W-1:0] out_byte;
        logic [BYTE_W-1:0] crc;
        logic              crc_en;
        logic              last;
        logic              lost;
        logic              crc_phase;
    } seq_regs_t;

    localparam seq_regs_t REGS_RESET = '{
        st:        ST_IDLE,
        kind:      KIND_NONE,
        id:        '0,
        out_byte:  '0,
        crc:       CRC_INIT,
        crc_en:    1'b0,
        last:      1'b0,
        lost:      1'b0,
        crc_phase: 1'b0
    };

    seq_regs_t r_q, r_d;
    ifr_kind_e pick_kind;
    logic [BYTE_W-1:0] crc_next;
    logic lost_now;

    ifr_kind_pick #(.N_KIND(3)) u_pick (
        .req  ({sel_data, sel_nodes, sel_single}),
        .kind (pick_kind)
    );

    ifr_crc_step #(.W(BYTE_W), .POLY(CRC_POLY)) u_crc (
        .crc_in  (r_q.crc),
        .data    (src_byte),
        .crc_out (crc_next)
    );

    assign lost_now  = r_q.lost | arb_lost;
    assign src_ready = (r_q.st == ST_FETCH);
    assign tx_valid  = (r_q.st == ST_SEND);
    assign tx_byte   = r_q.out_byte;
    assign done      = (r_q.st == ST_DONE);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (trig) begin
                    if (pick_kind == KIND_NONE) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.st     = ST_ARMED;
                        r_d.kind   = pick_kind;
                        r_d.id     = node_id;
                        r_d.crc_en = crc_en;
                    end
                end
            end
            ST_ARMED: begin
                if (frame_eod) begin
                    r_d.crc       = CRC_INIT;
                    r_d.crc_phase = 1'b0;
                    r_d.last      = 1'b0;
                    if (r_q.kind == KIND_DATA) begin
                        r_d.st = ST_FETCH;
                    end else begin
                        r_d.out_byte = r_q.id;
                        r_d.st       = ST_SEND;
                    end
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    r_d.out_byte = src_byte;
                    r_d.last     = src_last;
                    r_d.crc      = crc_next;
                    r_d.st       = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    r_d.lost = 1'b0;
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                r_d.lost = lost_now;
                if (byte_end) begin
                    unique case (r_q.kind)
                        KIND_NODES: r_d.st = lost_now ? ST_SEND : ST_DONE;
                        KIND_DATA: begin
                            if (lost_now) begin
                                r_d.st = ST_DONE;
                            end else if (!r_q.last) begin
                                r_d.st = ST_FETCH;
                            end else if (r_q.crc_en && !r_q.crc_phase) begin
                                r_d.out_byte  = ~r_q.crc;
                                r_d.crc_phase = 1'b1;
                                r_d.st        = ST_SEND;
                            end else begin
                                r_d.st = ST_DONE;
                            end
                        end
                        default: r_d.st = ST_DONE;
                    endcase
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // R9: an offered byte is held until taken
    a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R5: every node-ID offer carries the identifier latched at the trigger
    a_r5_same_id: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && r_q.kind == KIND_NODES) |-> (tx_byte == r_q.id));

    // R2: empty request completes in the next cycle
    a_r2_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && trig && !(sel_single || sel_nodes || sel_data)) |=> done);

    // R1: the single-byte bit wins over any other
    a_r1_single_first: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && trig && sel_single) |=> (r_q.kind == KIND_SINGLE));

    // R10: completion is a single-cycle pulse with no offer after it
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !tx_valid));

    // R6: the source is only drawn from in a data response
    a_r6_fetch_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (r_q.kind == KIND_DATA));

endmodule

// File: tb/ifr_tx_seq_tb.sv
`timescale 1ns/1ps
module ifr_tx_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0, sel_single = 1'b0, sel_nodes = 1'b0, sel_data = 1'b0;
    logic       crc_en = 1'b0;
    logic [7:0] node_id = 8'h00;
    logic       frame_eod = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_byte = 8'h00;
    logic       src_last = 1'b0;
    logic       src_ready;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_ready = 1'b0, arb_lost = 1'b0, byte_end = 1'b0;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] data_buf [0:15];
    int         data_len = 0;
    int         data_idx = 0;
    logic       take_pend = 1'b0;

    always #2.5 clk = ~clk;

    ifr_tx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .sel_single(sel_single), .sel_nodes(sel_nodes), .sel_data(sel_data),
        .crc_en(crc_en), .node_id(node_id), .frame_eod(frame_eod),
        .src_valid(src_valid), .src_byte(src_byte), .src_last(src_last),
        .src_ready(src_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .arb_lost(arb_lost), .byte_end(byte_end), .done(done)
    );

    // source stream feeder: a byte is consumed at the edge after src_ready is seen
    always @(negedge clk) begin
        if (take_pend) data_idx = data_idx + 1;
        take_pend = src_ready && src_valid;
        src_valid = (data_idx < data_len);
        src_byte  = (data_idx < data_len) ? data_buf[data_idx] : 8'h00;
        src_last  = (data_idx == data_len - 1);
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_ref(input int n);
        logic [7:0] c = 8'hFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[7] ^ data_buf[k][b];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
            end
        end
        return ~c;
    endfunction

    task automatic pulse_trig(input logic [2:0] sel, input logic ce);
        @(negedge clk);
        {sel_data, sel_nodes, sel_single} = sel;
        crc_en = ce;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        {sel_data, sel_nodes, sel_single} = 3'b000;
        crc_en = 1'b0;
    endtask

    // transmitter model: stall one cycle, take the byte, optionally lose, end the byte
    task automatic serve(input logic lose, output logic [7:0] got, output logic seen);
        int w = 0;
        seen = 1'b0;
        got  = 8'h00;
        while (!tx_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        if (!tx_valid) return;
        seen = 1'b1;
        got  = tx_byte;
        @(negedge clk);
        check(tx_valid && tx_byte == got, "R9 hold", tx_byte, got);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        @(negedge clk);
        if (lose) begin
            arb_lost = 1'b1;
            @(negedge clk);
            arb_lost = 1'b0;
        end
        byte_end = 1'b1;
        @(negedge clk);
        byte_end = 1'b0;
    endtask

    task automatic expect_quiet(input string tag, input int cycles);
        logic any = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            any = any | tx_valid | done;
        end
        check(!any, tag, any, 0);
    endtask

    task automatic run_case(input logic [2:0] sel, input logic ce, input int variant);
        logic [7:0] got;
        logic seen;
        int   kind;
        logic [7:0] id;
        id = 8'h40 + 8'(variant);
        node_id = id;
        kind = sel[0] ? 1 : sel[1] ? 2 : sel[2] ? 3 : 0;
        data_len = 0;
        if (kind == 3) begin
            for (int k = 0; k < (variant % 4) + 1; k++) data_buf[k] = 8'(8'h11 * (k + 1) + variant);
        end
        pulse_trig(sel, ce);
        if (kind == 0) begin
            check(done == 1'b1 && tx_valid == 1'b0, "R2 empty trigger done", done, 1);
            expect_quiet("R2 nothing sent", 4);
            return;
        end
        // armed: nothing offered; a second trigger with another kind is ignored
        check(!tx_valid && !done, "R3 quiet before eod", tx_valid, 0);
        @(negedge clk);
        {sel_data, sel_nodes, sel_single} = (kind == 1) ? 3'b100 : 3'b001;
        trig = 1'b1;
        node_id = 8'hEE;
        @(negedge clk);
        trig = 1'b0;
        {sel_data, sel_nodes, sel_single} = 3'b000;
        check(!tx_valid, "R11 retrigger ignored", tx_valid, 0);
        if (kind == 3) begin
            data_len = (variant % 4) + 1;
            data_idx = 0;
            take_pend = 1'b0;
        end
        frame_eod = 1'b1;
        @(negedge clk);
        frame_eod = 1'b0;
        if (kind != 3) check(tx_valid, "R3 offer after eod", tx_valid, 1);
        if (kind == 1) begin
            serve(variant[0], got, seen);
            check(seen && got == id, "R1 R4 single byte", got, id);
            check(done, "R4 done after byte end", done, 1);
            expect_quiet("R4 no second byte", 4);
        end else if (kind == 2) begin
            int rounds = (variant % 3) + 1;
            for (int r = 0; r < rounds; r++) begin
                serve(1'b1, got, seen);
                check(seen && got == id, "R5 lost round id", got, id);
                check(!done, "R5 no done after loss", done, 0);
            end
            serve(1'b0, got, seen);
            check(seen && got == id, "R5 winning id", got, id);
            check(done, "R5 done after win", done, 1);
            expect_quiet("R5 idle after win", 3);
        end else begin
            for (int k = 0; k < data_len; k++) begin
                serve(1'b0, got, seen);
                check(seen && got == data_buf[k], "R6 data byte order", got, data_buf[k]);
            end
            if (ce) begin
                serve(1'b0, got, seen);
                check(seen && got == crc_ref(data_len), "R7 crc byte", got, crc_ref(data_len));
            end
            check(done, "R6 R7 done after final byte", done, 1);
            expect_quiet("R7 nothing after end", 3);
        end
        data_len = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic seen;
        repeat (3) @(negedge clk);
        check(!tx_valid && !src_ready && !done, "R10 reset outputs idle", {tx_valid, src_ready, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep every request combination, with and without CRC
        for (int v = 0; v < 16; v++) begin
            run_case(3'(v % 8), v >= 8, v);
            @(negedge clk);
        end

        // R7 known check value: CRC over "123456789" is 0x4B
        for (int k = 0; k < 9; k++) data_buf[k] = 8'h31 + 8'(k);
        pulse_trig(3'b100, 1'b1);
        data_len = 9;
        data_idx = 0;
        take_pend = 1'b0;
        frame_eod = 1'b1;
        @(negedge clk);
        frame_eod = 1'b0;
        for (int k = 0; k < 9; k++) begin
            serve(1'b0, got, seen);
            check(seen && got == data_buf[k], "R6 long data byte", got, data_buf[k]);
        end
        serve(1'b0, got, seen);
        check(seen && got == 8'h4B, "R7 crc check value", got, 8'h4B);
        check(done, "R7 done after crc", done, 1);
        data_len = 0;
        @(negedge clk);

        // R8: loss on second of three data bytes ends the response
        for (int k = 0; k < 3; k++) data_buf[k] = 8'hA0 + 8'(k);
        pulse_trig(3'b100, 1'b1);
        data_len = 3;
        data_idx = 0;
        take_pend = 1'b0;
        frame_eod = 1'b1;
        @(negedge clk);
        frame_eod = 1'b0;
        serve(1'b0, got, seen);
        check(seen && got == 8'hA0, "R8 first data byte", got, 8'hA0);
        serve(1'b1, got, seen);
        check(seen && got == 8'hA1, "R8 lost data byte", got, 8'hA1);
        check(done, "R8 done after loss", done, 1);
        expect_quiet("R8 no byte after loss", 6);
        check(data_idx == 2, "R8 source not drawn again", data_idx, 2);
        data_len = 0;

        // R10: fresh request after all of the above still works
        node_id = 8'h5A;
        pulse_trig(3'b001, 1'b0);
        @(negedge clk);
        frame_eod = 1'b1;
        @(negedge clk);
        frame_eod = 1'b0;
        serve(1'b0, got, seen);
        check(seen && got == 8'h5A, "R10 request accepted again", got, 8'h5A);
        check(done, "R10 done pulse", done, 1);
        @(negedge clk);
        check(!done, "R10 done lasts one cycle", done, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule